// File: doc/BRIEF.md
# Embedded-Clock Word Serializer Framer

This block turns a stream of 10-bit parallel words into a framed serial bit stream. The framed stream carries its own timing. Every word goes out as a 12-bit frame. The frame opens with a fixed one and closes with a fixed zero, so a receiver can find word boundaries from the fixed zero-to-one step between adjacent frames. Serial bits advance on a synchronous bit enable that pulses twelve times per word. The word clock arrives as an ordinary input that is sampled in the same clock domain. A configuration input picks whether each word is captured on the rising or the falling word-clock edge.

A receiver needs a training pattern to acquire the link. A sync request is accepted when either of two request inputs is held high for six consecutive word-clock edges. The block then ignores the parallel data and sends a fixed-length burst of sync frames. Each sync frame is six ones followed by six zeros. A driver-enable flag stands in for the tri-state output. It is high only when the output enable is high, the power input is high, neither request is high, and the block has finished initializing. Driving the power input low clears the block. After reset, and again after power is restored, the block waits 1026 word-clock edges before it drives any frame.

Top module: `emb_clk_serializer`

## Requirements
- R1: Each frame is 12 bits, sent in this order: a start bit of 1, then the 10 payload bits least-significant first, then a stop bit of 0.
- R2: The serial output advances only on cycles where `bit_en` is high, and holds its value between those pulses. A frame boundary falls after every 12th `bit_en` pulse.
- R3: With `edge_fall` = 0, `din` is captured on the rising edge of `word_clk`. With `edge_fall` = 1, it is captured on the falling edge. The captured word goes into the next frame.
- R4: If `sync_req_a` or `sync_req_b` is high on 6 consecutive selected word-clock edges, the payload is ignored and sync frames are sent. A sync frame is bits 0 to 5 at 1 and bits 6 to 11 at 0, with bit 0 sent first. A request held for only 5 edges has no effect on the data stream.
- R5: A sync burst is exactly 1026 frames. Once started, it runs to the end even if the request drops. If the request has met the hold rule when the burst ends, a new burst starts at once.
- R6: `drv_en` is high only when `out_en` = 1, `pwr_on` = 1, `sync_req_a` = 0, `sync_req_b` = 0 and initialization is complete. While `drv_en` = 0, `ser_out` is 0.
- R7: Pulling `out_en` low and raising it again does not restart initialization and does not disturb the frame sequence. Frames that follow the re-enable carry the words captured during that time.
- R8: While `pwr_on` = 0, all state is cleared. After reset, and after `pwr_on` returns to 1, no frame is driven until 1026 selected word-clock edges have been seen. The frame that follows the load after the 1026th edge is driven.
- R9: The initialization status that qualifies `drv_en` changes only at frame boundaries, so a frame is never partly driven because initialization completed mid-frame.
- R10: During and after synchronous reset, `drv_en` and `ser_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-rate enable, twelve pulses per word |
| word_clk | input | 1 | Word clock, sampled in the `clk` domain |
| edge_fall | input | 1 | 0: capture on rising word-clock edge, 1: on falling edge |
| din | input | 10 | Parallel payload word |
| sync_req_a | input | 1 | Sync request, first input |
| sync_req_b | input | 1 | Sync request, second input |
| out_en | input | 1 | Output enable |
| pwr_on | input | 1 | Low puts the block in power-down |
| ser_out | output | 1 | Serial frame bit, 0 when not driven |
| drv_en | output | 1 | High when the serial output is being driven |

## Verification
The hardest case to reach is a second sync burst that starts because the request is still held when the first burst ends. While a request is high, the output is not driven, so the whole first burst runs unseen. The stimulus holds one request for 1040 words and then drops it, which leaves the tail of the second burst and the return to payload visible. A word-level reference model in the bench tracks the initialization count, the hold count and the burst count. From these it predicts, for every frame, whether the frame is driven and what it contains.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

    localparam int unsigned PAYLOAD_W_DEF = 10;
    localparam int unsigned SYNC_HOLD_DEF = 6;
    localparam int unsigned BURST_LEN_DEF = 1026;
    localparam int unsigned INIT_LEN_DEF  = 1026;

    typedef enum logic {
        LATCH_RISE = 1'b0,
        LATCH_FALL = 1'b1
    } latch_edge_e;

    typedef enum logic {
        SRC_DATA = 1'b0,
        SRC_SYNC = 1'b1
    } frame_src_e;

    typedef struct packed {
        logic       frame_ok;
        frame_src_e src;
    } link_state_t;

    function automatic int unsigned cnt_w(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/ecs_word_sampler.sv
module ecs_word_sampler
    import ecs_pkg::*;
#(
    parameter int unsigned PAYLOAD_W = PAYLOAD_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 word_clk,
    input  latch_edge_e          edge_mode,
    input  logic [PAYLOAD_W-1:0] din,
    output logic                 word_tick,
    output logic [PAYLOAD_W-1:0] held_data
);

    logic wc_now;
    logic wc_prev;
    logic saw_rise;
    logic saw_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            wc_now  <= 1'b0;
            wc_prev <= 1'b0;
        end else begin
            wc_now  <= word_clk;
            wc_prev <= wc_now;
        end
    end

    assign saw_rise = wc_now & ~wc_prev;
    assign saw_fall = ~wc_now & wc_prev;

    always_comb begin
        unique case (edge_mode)
            LATCH_RISE: word_tick = saw_rise;
            LATCH_FALL: word_tick = saw_fall;
            default:    word_tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_data <= '0;
        end else if (word_tick) begin
            held_data <= din;
        end
    end

    // R3
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        word_tick |=> !word_tick);

endmodule

// File: rtl/ecs_link_ctrl.sv
module ecs_link_ctrl
    import ecs_pkg::*;
#(
    parameter int unsigned SYNC_HOLD = SYNC_HOLD_DEF,
    parameter int unsigned BURST_LEN = BURST_LEN_DEF,
    parameter int unsigned INIT_LEN  = INIT_LEN_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_on,
    input  logic        word_tick,
    input  logic        sync_any,
    input  logic        frame_load,
    output link_state_t link_st
);

    localparam int unsigned INIT_W  = cnt_w(INIT_LEN);
    localparam int unsigned HOLD_W  = cnt_w(SYNC_HOLD);
    localparam int unsigned BURST_W = cnt_w(BURST_LEN);

    logic [INIT_W-1:0]  init_cnt;
    logic [HOLD_W-1:0]  sreq_cnt;
    logic [BURST_W-1:0] burst_left;
    logic               frame_ok_q;
    logic               init_done;
    logic               hold_met;
    logic               burst_busy;

    assign init_done  = (init_cnt == INIT_W'(INIT_LEN));
    assign hold_met   = (sreq_cnt == HOLD_W'(SYNC_HOLD));
    assign burst_busy = (burst_left != '0);

    always_ff @(posedge clk) begin
        if (rst || !pwr_on) begin
            init_cnt   <= '0;
            sreq_cnt   <= '0;
            burst_left <= '0;
            frame_ok_q <= 1'b0;
        end else begin
            if (word_tick) begin
                if (!init_done) begin
                    init_cnt <= init_cnt + 1'b1;
                end
                if (sync_any) begin
                    if (!hold_met) begin
                        sreq_cnt <= sreq_cnt + 1'b1;
                    end
                end else begin
                    sreq_cnt <= '0;
                end
            end
            if (frame_load) begin
                frame_ok_q <= init_done;
                if (burst_busy) begin
                    burst_left <= burst_left - 1'b1;
                end else if (hold_met) begin
                    burst_left <= BURST_W'(BURST_LEN - 1);
                end
            end
        end
    end

    always_comb begin
        link_st.frame_ok = frame_ok_q;
        link_st.src      = (burst_busy || hold_met) ? SRC_SYNC : SRC_DATA;
    end

    // R8
    init_guard_chk: assert property (@(posedge clk) disable iff (rst)
        frame_ok_q |-> (init_cnt == INIT_W'(INIT_LEN)));

    // R9
    ok_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_load && pwr_on) |=> $stable(frame_ok_q));

    // R5
    burst_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_on && burst_busy && !frame_load) |=> (burst_left == $past(burst_left)));

    // R4
    short_req_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_on && !burst_busy && !hold_met && frame_load) |=> (burst_left == '0));

    // R4
    hold_range_chk: assert property (@(posedge clk) disable iff (rst)
        sreq_cnt <= HOLD_W'(SYNC_HOLD));

endmodule

// File: rtl/ecs_frame_shifter.sv
module ecs_frame_shifter
    import ecs_pkg::*;
#(
    parameter int unsigned PAYLOAD_W = PAYLOAD_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pwr_on,
    input  logic                 bit_en,
    input  frame_src_e           src,
    input  logic [PAYLOAD_W-1:0] held_data,
    output logic                 frame_load,
    output logic                 ser_bit
);

    localparam int unsigned FRAME_W = PAYLOAD_W + 2;
    localparam int unsigned CNT_W   = cnt_w(FRAME_W - 1);

    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;
    logic [FRAME_W-1:0] data_frame;
    logic [FRAME_W-1:0] sync_frame;
    logic [FRAME_W-1:0] next_frame;

    for (genvar gi = 0; gi < FRAME_W; gi++) begin : g_sync
        assign sync_frame[gi] = (gi < FRAME_W / 2) ? 1'b1 : 1'b0;
    end

    always_comb begin
        data_frame              = '0;
        data_frame[0]           = 1'b1;
        data_frame[PAYLOAD_W:1] = held_data;
        data_frame[FRAME_W-1]   = 1'b0;
    end

    assign next_frame = (src == SRC_SYNC) ? sync_frame : data_frame;
    assign frame_load = bit_en && (bit_cnt == CNT_W'(FRAME_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
        end else if (bit_en) begin
            bit_cnt <= frame_load ? '0 : bit_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_on) begin
            shreg <= '0;
        end else if (frame_load) begin
            shreg <= next_frame;
        end else if (bit_en) begin
            shreg <= {1'b0, shreg[FRAME_W-1:1]};
        end
    end

    assign ser_bit = shreg[0];

    // R2
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        (!bit_en && pwr_on) |=> $stable(shreg));

    // R1
    frame_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_load && pwr_on && src == SRC_DATA) |=>
            (shreg[0] && !shreg[FRAME_W-1] && shreg[PAYLOAD_W:1] == $past(held_data)));

endmodule

// File: rtl/emb_clk_serializer.sv
module emb_clk_serializer
    import ecs_pkg::*;
#(
    parameter int unsigned PAYLOAD_W = PAYLOAD_W_DEF,
    parameter int unsigned SYNC_HOLD = SYNC_HOLD_DEF,
    parameter int unsigned BURST_LEN = BURST_LEN_DEF,
    parameter int unsigned INIT_LEN  = INIT_LEN_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_en,
    input  logic                 word_clk,
    input  logic                 edge_fall,
    input  logic [PAYLOAD_W-1:0] din,
    input  logic                 sync_req_a,
    input  logic                 sync_req_b,
    input  logic                 out_en,
    input  logic                 pwr_on,
    output logic                 ser_out,
    output logic                 drv_en
);

    latch_edge_e          edge_mode;
    logic                 word_tick;
    logic [PAYLOAD_W-1:0] held_data;
    logic                 frame_load;
    logic                 ser_bit;
    logic                 sync_any;
    link_state_t          link_st;

    assign edge_mode = latch_edge_e'(edge_fall);
    assign sync_any  = sync_req_a | sync_req_b;

    ecs_word_sampler #(.PAYLOAD_W(PAYLOAD_W)) u_sampler (
        .clk       (clk),
        .rst       (rst),
        .word_clk  (word_clk),
        .edge_mode (edge_mode),
        .din       (din),
        .word_tick (word_tick),
        .held_data (held_data)
    );

    ecs_link_ctrl #(
        .SYNC_HOLD (SYNC_HOLD),
        .BURST_LEN (BURST_LEN),
        .INIT_LEN  (INIT_LEN)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .pwr_on     (pwr_on),
        .word_tick  (word_tick),
        .sync_any   (sync_any),
        .frame_load (frame_load),
        .link_st    (link_st)
    );

    ecs_frame_shifter #(.PAYLOAD_W(PAYLOAD_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .pwr_on     (pwr_on),
        .bit_en     (bit_en),
        .src        (link_st.src),
        .held_data  (held_data),
        .frame_load (frame_load),
        .ser_bit    (ser_bit)
    );

    assign drv_en  = link_st.frame_ok & out_en & pwr_on & ~sync_any;
    assign ser_out = drv_en & ser_bit;

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!drv_en && !ser_out));

endmodule

// File: tb/emb_clk_serializer_tb_top.sv
module emb_clk_serializer_tb_top;

    localparam int DW   = 10;
    localparam int FW   = DW + 2;
    localparam int WPER = 24;
    localparam logic [FW-1:0] SYNC_PAT = 12'h03F;

    typedef struct {
        bit pwr;
        bit oe;
        bit sa;
        bit sb;
        bit fall;
    } ctl_t;

    typedef struct {
        bit            drv;
        logic [FW-1:0] frame;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bit_en = 1'b0;
    logic          word_clk = 1'b0;
    logic          edge_fall = 1'b0;
    logic [DW-1:0] din = '0;
    logic          sync_req_a = 1'b0;
    logic          sync_req_b = 1'b0;
    logic          out_en = 1'b1;
    logic          pwr_on = 1'b1;
    logic          ser_out;
    logic          drv_en;

    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = -1;
    int   wcount = 0;
    bit   mon_on = 1'b0;
    bit   finished = 1'b0;
    exp_t exp_q[$];

    int   m_init = 0;
    int   m_sreq = 0;
    int   m_burst = 0;
    ctl_t c_prev = '{pwr: 1, oe: 1, sa: 0, sb: 0, fall: 0};

    logic [FW-1:0] got_f;
    logic [FW-1:0] got_d;
    logic          last_ser = 1'b0;
    int            ph;
    int            jb;

    always #4 clk = ~clk;

    emb_clk_serializer dut_i (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .word_clk   (word_clk),
        .edge_fall  (edge_fall),
        .din        (din),
        .sync_req_a (sync_req_a),
        .sync_req_b (sync_req_b),
        .out_en     (out_en),
        .pwr_on     (pwr_on),
        .ser_out    (ser_out),
        .drv_en     (drv_en)
    );

    function automatic logic [DW-1:0] pat(input int w);
        return DW'((w * 181 + 77) ^ (w >> 3));
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Word-level reference model: tick, then frame load, then drive decision.
    task automatic model_step(input ctl_t c, input logic [DW-1:0] d, input string tag);
        exp_t          e;
        bit            ok;
        logic [FW-1:0] fr;
        logic [DW-1:0] cap;
        ok = 0;
        fr = '0;
        if (!c_prev.pwr) begin
            m_init = 0; m_sreq = 0; m_burst = 0;
        end else begin
            if (m_init < 1026) m_init++;
            if (c_prev.sa || c_prev.sb) m_sreq = (m_sreq < 6) ? m_sreq + 1 : 6;
            else m_sreq = 0;
            ok = (m_init >= 1026);
            if (m_burst > 0) begin
                fr = SYNC_PAT; m_burst--;
            end else if (m_sreq == 6) begin
                fr = SYNC_PAT; m_burst = 1025;
            end else begin
                cap = c_prev.fall ? ~d : d;
                fr  = {1'b0, cap, 1'b1};
            end
        end
        pwr_on     = c.pwr;
        out_en     = c.oe;
        sync_req_a = c.sa;
        sync_req_b = c.sb;
        edge_fall  = c.fall;
        e.drv   = ok && c.oe && c.pwr && !c.sa && !c.sb;
        e.frame = fr;
        e.tag   = tag;
        exp_q.push_back(e);
        c_prev = c;
    endtask

    task automatic drive_word(input ctl_t c, input string tag, input bit push_it);
        logic [DW-1:0] d;
        d = pat(wcount);
        for (int k = 0; k < WPER; k++) begin
            @(negedge clk);
            bit_en = (k % 2 == 0);
            if (k == 0) begin word_clk = 1'b1; din = d; end
            if (k == 12) begin word_clk = 1'b0; din = ~d; end
            if (k == WPER - 1 && push_it) model_step(c, d, tag);
            cyc = wcount * WPER + k;
        end
        wcount++;
    endtask

    task automatic run_words(input int n, input ctl_t c, input string tag);
        for (int i = 0; i < n; i++) drive_word(c, tag, 1'b1);
    endtask

    task automatic score_frame();
        exp_t e;
        n_chk++;
        if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R1 frame with no expectation got=%h expected=none", got_f);
            return;
        end
        e = exp_q.pop_front();
        if (got_d != (e.drv ? {FW{1'b1}} : {FW{1'b0}})) begin
            n_bad++;
            $display("FAIL %s drive mismatch slot got=%b expected=%0d", e.tag, got_d, e.drv);
        end else if (e.drv && got_f !== e.frame) begin
            n_bad++;
            $display("FAIL %s frame got=%h expected=%h", e.tag, got_f, e.frame);
        end else if (!e.drv && got_f !== '0) begin
            n_bad++;
            $display("FAIL R6 undriven output got=%h expected=000", got_f);
        end
    endtask

    // Monitor: one sample per bit slot, plus a hold check between pulses.
    always @(negedge clk) begin
        #1;
        if (mon_on && cyc >= 23) begin
            ph = (cyc - 23) % WPER;
            if (ph % 2 == 0) begin
                jb = ph / 2;
                got_f[jb] = ser_out;
                got_d[jb] = drv_en;
                last_ser  = ser_out;
                if (jb == FW - 1) score_frame();
            end else begin
                n_chk++;
                if (ser_out !== last_ser) begin
                    n_bad++;
                    $display("FAIL R2 output moved without bit_en got=%b expected=%b", ser_out, last_ser);
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired got=running expected=finished");
        summary();
    end

    initial begin
        ctl_t base;
        ctl_t cur;
        base = '{pwr: 1, oe: 1, sa: 0, sb: 0, fall: 0};
        repeat (4) @(negedge clk);
        n_chk++;
        if (drv_en !== 1'b0 || ser_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset outputs got=%b%b expected=00", drv_en, ser_out);
        end
        @(negedge clk);
        rst = 1'b0;
        mon_on = 1'b1;

        // R8 power-up initialization, then R1 plain framing
        run_words(1030, base, "R8");
        run_words(20, base, "R1");
        // R3 falling-edge capture and back
        cur = base; cur.fall = 1;
        run_words(20, cur, "R3");
        run_words(10, base, "R3");
        // R7 output enable drop and restore
        cur = base; cur.oe = 0;
        run_words(4, cur, "R7");
        run_words(10, base, "R7");
        // R4 five-edge request is ignored
        cur = base; cur.sa = 1;
        run_words(5, cur, "R4");
        run_words(10, base, "R4");
        // R4 six-edge request starts a burst that R5 says completes
        cur = base; cur.sb = 1;
        run_words(6, cur, "R4");
        run_words(1040, base, "R5");
        // R5 request held past the burst end retriggers
        cur = base; cur.sa = 1;
        run_words(1040, cur, "R6");
        run_words(1040, base, "R5");
        // R8 power-down clears and reinitializes, R9 clean boundary
        cur = base; cur.pwr = 0;
        run_words(3, cur, "R8");
        run_words(1035, base, "R9");

        drive_word(base, "", 1'b0);
        mon_on = 1'b0;
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R1 unconsumed frames got=%0d expected=0", exp_q.size());
        end
        summary();
    end

endmodule